// File: doc/BRIEF.md
# Restoring Signed Integer Divider

This block divides one two's-complement integer by another over several clock cycles and returns a truncated quotient together with a remainder. It takes the magnitudes of both operands and runs the restoring shift-subtract loop on them. A 2N-bit working remainder starts out holding the dividend magnitude. A 2N-bit divisor register starts out holding the divisor magnitude in its upper half and moves one place to the right after every trial. Each trial either keeps the difference or keeps the old remainder, and it shifts the matching quotient bit in from the right. The loop runs N+1 trials. A sign stage then fixes up the results: the quotient is negated when the two operand signs differ, and the remainder takes the sign of the dividend.

Control is a plain start/busy/done handshake with no data queueing. The block accepts `start` only while `busy` is low, and at that edge it captures both operands. While `busy` is high it holds off further work, and any `start` pulse in that time is dropped without effect, which is the only back-pressure it applies. When the result is ready, `done` goes high for exactly one cycle. From that point the outputs hold their values until the next accepted run. A zero divisor does not stop the run. It raises a status flag and gives a fixed result.

Top module: `rdiv_top`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `quotient`, `remainder` and `div_by_zero` are all zero.
- R2: When `start` is high and `busy` is low at a rising edge, the run is accepted. `busy` is then high for exactly WIDTH+2 cycles.
- R3: `done` is high for exactly one cycle. It rises WIDTH+2 cycles after the accepting edge, in the same cycle that `busy` falls.
- R4: When both operands are zero or positive and the divisor is non-zero, `quotient` and `remainder` are the unsigned quotient and remainder of the two values.
- R5: When the operand signs differ, `quotient` is the negated quotient of the magnitudes, so division truncates toward zero.
- R6: When the divisor is non-zero, `remainder` is zero or carries the dividend's sign, and its magnitude is smaller than the divisor's magnitude.
- R7: Dividing the most negative value by -1 gives a wrapped quotient equal to the most negative value and a remainder of zero, with `div_by_zero` low.
- R8: A divisor of zero sets `div_by_zero` to 1, `quotient` to all ones and `remainder` to the unchanged dividend. Any non-zero divisor gives `div_by_zero` equal to 0.
- R9: `quotient`, `remainder` and `div_by_zero` change only in the cycle in which `done` is high. A `start` that arrives while `busy` is high changes neither the timing nor the results, and it produces no second `done`.
- R10: Both operands are captured at the accepting edge. Changing `dividend` or `divisor` later during the run has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Requests a division; taken only while busy is low |
| dividend | input | WIDTH | Two's-complement dividend |
| divisor | input | WIDTH | Two's-complement divisor |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle pulse when the results are updated |
| quotient | output | WIDTH | Signed quotient, truncated toward zero |
| remainder | output | WIDTH | Signed remainder with the dividend's sign |
| div_by_zero | output | 1 | Set when the last divisor was zero |

## Verification
Every result of a run is due at one fixed point: WIDTH+2 cycles after the accepting edge, `busy` is low, `done` is high and the three result outputs hold their new values. One cycle later `done` has dropped again. The bench drives its inputs on falling edges and samples on falling edges as well. It counts rising edges from the accepting edge, expects `busy` high after edges 0 through WIDTH+1, and reads the results only after edge WIDTH+2. It then checks that nothing moves in the cycles that follow. All 256 operand pairs of a 4-bit instance are swept, with the operand inputs scrambled right after each accepting edge, and the expected values come from integer division in the bench.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } rdiv_state_e;
endpackage

// File: rtl/rdiv_prep.sv
module rdiv_prep #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] dvd_in,
  input  logic [WIDTH-1:0] dvs_in,
  output logic [WIDTH-1:0] dvd_mag,
  output logic [WIDTH-1:0] dvs_mag,
  output logic             dvd_neg,
  output logic             dvs_neg,
  output logic             dvs_zero
);
  assign dvd_neg  = dvd_in[WIDTH-1];
  assign dvs_neg  = dvs_in[WIDTH-1];
  // The magnitude of the most negative value is still correct when read unsigned
  assign dvd_mag  = dvd_neg ? (~dvd_in + 1'b1) : dvd_in;
  assign dvs_mag  = dvs_neg ? (~dvs_in + 1'b1) : dvs_in;
  assign dvs_zero = (dvs_in == '0);
endmodule

// File: rtl/rdiv_step.sv
module rdiv_step #(
  parameter int WIDTH = 16
) (
  input  logic [2*WIDTH-1:0] rem_in,
  input  logic [2*WIDTH-1:0] dvs_in,
  output logic [2*WIDTH-1:0] rem_out,
  output logic               q_bit
);
  localparam int DW = 2*WIDTH;

  logic [DW:0] trial;

  // One guard bit above the 2N-bit operands keeps the trial sign exact
  assign trial   = {1'b0, rem_in} - {1'b0, dvs_in};
  assign q_bit   = ~trial[DW];
  // A negative trial restores the remainder by keeping the old value
  assign rem_out = q_bit ? trial[DW-1:0] : rem_in;
endmodule

// File: rtl/rdiv_fix.sv
module rdiv_fix #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] q_mag,
  input  logic [WIDTH-1:0] r_mag,
  input  logic [WIDTH-1:0] dvd_raw,
  input  logic             dvd_neg,
  input  logic             dvs_neg,
  input  logic             dvs_zero,
  output logic [WIDTH-1:0] q_out,
  output logic [WIDTH-1:0] r_out
);
  always_comb begin
    if (dvs_zero) begin
      q_out = '1;
      r_out = dvd_raw;
    end else begin
      q_out = (dvd_neg ^ dvs_neg) ? (~q_mag + 1'b1) : q_mag;
      r_out = dvd_neg ? (~r_mag + 1'b1) : r_mag;
    end
  end
endmodule

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
  import rdiv_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic finish,
  output logic busy,
  output logic done
);
  localparam int ITERS = WIDTH + 1;
  localparam int CW    = $clog2(ITERS + 1);
  localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

  rdiv_state_e   state_q;
  logic [CW-1:0] cnt_q;

  assign busy   = (state_q != ST_IDLE);
  assign load   = (state_q == ST_IDLE) && start;
  assign step   = (state_q == ST_RUN);
  assign finish = (state_q == ST_FIX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= finish;
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          if (cnt_q == LAST) state_q <= ST_FIX;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdiv_top.sv
module rdiv_top #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             div_by_zero
);
  localparam int DW = 2*WIDTH;

  logic             load, step, finish;
  logic [WIDTH-1:0] dvd_mag, dvs_mag;
  logic             dvd_neg, dvs_neg, dvs_zero;

  logic [DW-1:0]    rem_q, dvs_q, rem_nx;
  logic [WIDTH-1:0] quo_q, dvd_raw_q;
  logic             q_bit;
  logic             dvd_neg_q, dvs_neg_q, dvs_zero_q;
  logic [WIDTH-1:0] q_fixed, r_fixed;

  rdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load), .step(step), .finish(finish),
    .busy(busy), .done(done)
  );

  rdiv_prep #(.WIDTH(WIDTH)) u_prep (
    .dvd_in(dividend), .dvs_in(divisor),
    .dvd_mag(dvd_mag), .dvs_mag(dvs_mag),
    .dvd_neg(dvd_neg), .dvs_neg(dvs_neg), .dvs_zero(dvs_zero)
  );

  rdiv_step #(.WIDTH(WIDTH)) u_step (
    .rem_in(rem_q), .dvs_in(dvs_q),
    .rem_out(rem_nx), .q_bit(q_bit)
  );

  rdiv_fix #(.WIDTH(WIDTH)) u_fix (
    .q_mag(quo_q), .r_mag(rem_q[WIDTH-1:0]), .dvd_raw(dvd_raw_q),
    .dvd_neg(dvd_neg_q), .dvs_neg(dvs_neg_q), .dvs_zero(dvs_zero_q),
    .q_out(q_fixed), .r_out(r_fixed)
  );

  // Working registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q      <= '0;
      dvs_q      <= '0;
      quo_q      <= '0;
      dvd_raw_q  <= '0;
      dvd_neg_q  <= 1'b0;
      dvs_neg_q  <= 1'b0;
      dvs_zero_q <= 1'b0;
    end else if (load) begin
      rem_q      <= {{WIDTH{1'b0}}, dvd_mag};
      dvs_q      <= {dvs_mag, {WIDTH{1'b0}}};
      quo_q      <= '0;
      dvd_raw_q  <= dividend;
      dvd_neg_q  <= dvd_neg;
      dvs_neg_q  <= dvs_neg;
      dvs_zero_q <= dvs_zero;
    end else if (step) begin
      rem_q <= rem_nx;
      quo_q <= {quo_q[WIDTH-2:0], q_bit};
      dvs_q <= {1'b0, dvs_q[DW-1:1]};
    end
  end

  // Result registers, written only when the run completes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quotient    <= '0;
      remainder   <= '0;
      div_by_zero <= 1'b0;
    end else if (finish) begin
      quotient    <= q_fixed;
      remainder   <= r_fixed;
      div_by_zero <= dvs_zero_q;
    end
  end
endmodule

// File: rtl/rdiv_checker.sv
module rdiv_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [WIDTH-1:0] dividend,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder,
  input logic             div_by_zero
);
  localparam int CW = $clog2(WIDTH + 4) + 1;
  localparam logic [CW-1:0] BUSY_LEN = CW'(WIDTH + 2);

  logic [CW-1:0] busy_cnt;
  logic          dvd_sign_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt   <= '0;
      dvd_sign_q <= 1'b0;
    end else begin
      busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
      if (start && !busy) dvd_sign_q <= dividend[WIDTH-1];
    end
  end

  p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_busy_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == BUSY_LEN));

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_with_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_results_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

  p_zero_divisor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_by_zero) |-> (quotient == '1));

  p_rem_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero && (remainder != '0)) |-> (remainder[WIDTH-1] == dvd_sign_q));
endmodule

bind rdiv_top rdiv_checker #(.WIDTH(WIDTH)) u_rdiv_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
  .busy(busy), .done(done), .quotient(quotient),
  .remainder(remainder), .div_by_zero(div_by_zero)
);

// File: tb/rdiv_top_bench.sv
module rdiv_top_bench;
  localparam int W = 4;
  localparam int LIMIT = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  rdiv_top #(.WIDTH(W)) u_rdiv_top (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder), .div_by_zero(div_by_zero)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > LIMIT) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=%0d", cycles, LIMIT);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    tests = tests + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Runs one division; inject issues a start while busy, scramble changes operands after capture
  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit inject, input bit scramble,
                         output logic [W-1:0] q, output logic [W-1:0] r,
                         output logic z, output int tbad, output int extra_done);
    tbad = 0;
    extra_done = 0;
    q = '0; r = '0; z = 1'b0;
    @(negedge clk);
    start = 1'b1; dividend = a; divisor = b;
    @(negedge clk);
    start = 1'b0;
    if (scramble) begin dividend = ~a; divisor = b + 4'd3; end
    for (int k = 0; k <= W + 6; k++) begin
      if (k <= W + 1) begin
        if (busy !== 1'b1 || done !== 1'b0) tbad++;
      end else if (k == W + 2) begin
        if (busy !== 1'b0 || done !== 1'b1) tbad++;
        q = quotient; r = remainder; z = div_by_zero;
      end else begin
        if (done !== 1'b0) extra_done++;
        if (quotient !== q || remainder !== r || div_by_zero !== z) extra_done++;
      end
      if (inject && k == 1) begin start = 1'b1; dividend = a ^ 4'h5; divisor = b ^ 4'h3; end
      if (inject && k == 2) start = 1'b0;
      if (k != W + 6) @(negedge clk);
    end
  endtask

  task automatic expect_vals(input logic [W-1:0] a, input logic [W-1:0] b,
                             output logic [W-1:0] eq, output logic [W-1:0] er,
                             output logic ez);
    int sa, sb;
    sa = int'($signed(a));
    sb = int'($signed(b));
    if (b == '0) begin
      eq = '1; er = a; ez = 1'b1;
    end else begin
      eq = W'(sa / sb); er = W'(sa % sb); ez = 1'b0;
    end
  endtask

  initial begin
    logic [W-1:0] q, r, eq, er;
    logic z, ez;
    int tbad, xd;
    string qtag;

    // R1: reset state, while held and after release
    repeat (3) @(negedge clk);
    check("R1 outputs during reset", int'({busy, done, div_by_zero, quotient, remainder}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", int'({busy, done, div_by_zero, quotient, remainder}), 0);

    // Exhaustive sweep of every operand pair
    for (int ia = 0; ia < (1 << W); ia++) begin
      for (int ib = 0; ib < (1 << W); ib++) begin
        run_div(W'(ia), W'(ib), 1'b0, 1'b1, q, r, z, tbad, xd);
        expect_vals(W'(ia), W'(ib), eq, er, ez);
        check("R2 R3 R10 busy/done timing", tbad, 0);
        check("R9 R3 hold after done", xd, 0);
        if (ib == 0)                               qtag = "R8 quotient";
        else if (ia == 8 && ib == 15)              qtag = "R7 quotient";
        else if (ia[W-1] != ib[W-1])               qtag = "R5 quotient";
        else if (ia[W-1] == 1'b0)                  qtag = "R4 quotient";
        else                                       qtag = "R5 R10 quotient";
        check(qtag, int'(q), int'(eq));
        check(ib == 0 ? "R8 remainder" : "R6 R4 remainder", int'(r), int'(er));
        check(ib == 0 ? "R8 div_by_zero set" : "R8 div_by_zero clear", int'(z), int'(ez));
      end
    end

    // R7: most negative over -1, named directly
    run_div(4'h8, 4'hF, 1'b0, 1'b0, q, r, z, tbad, xd);
    check("R7 wrapped quotient", int'(q), 8);
    check("R7 zero remainder", int'(r), 0);

    // R9: start while busy is ignored, results follow the first operands
    run_div(4'h7, 4'h2, 1'b1, 1'b0, q, r, z, tbad, xd);
    check("R9 timing with start while busy", tbad, 0);
    check("R9 no second done, outputs held", xd, 0);
    check("R9 quotient of first request", int'(q), 3);
    check("R9 remainder of first request", int'(r), 1);

    // R10: operands changed right after capture
    run_div(4'h9, 4'h2, 1'b0, 1'b1, q, r, z, tbad, xd);
    check("R10 quotient uses captured operands", int'(q), 13);
    check("R10 remainder uses captured operands", int'(r), 15);

    // R9: idle cycles leave results untouched
    repeat (6) @(negedge clk);
    check("R9 results stable while idle", int'({done, quotient, remainder}), int'({1'b0, 4'd13, 4'd15}));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule